// File: doc/BRIEF.md
# Acknowledge-Strobed DMA Word Port

This block is the device-side handshake for moving one received endpoint packet into system memory through an external DMA controller. A packet is announced with a one-cycle start pulse. The block then raises a request line. Each time the controller answers with its acknowledge input, the block places the current word at the head of the endpoint FIFO onto the data bus. The acknowledge alone selects the device and strobes the data, so no address decode and no read strobe are needed. When the acknowledge drops, the word is consumed. The word counter falls by one. After the final word a done flag is raised and the block stays quiet until the next packet is announced.

The FIFO side is a valid/ready stream. `fifo_valid` tells the block that a word is at the head. The block asserts `fifo_ready` for exactly one cycle to pop that word. It pops only while `fifo_valid` is high. While `fifo_valid` is low, the block withholds its request, and an acknowledge that arrives in the request phase is ignored. There are two request policies. In single-cycle mode the request drops for every word and returns only after the acknowledge has been seen low. In burst mode the request stays up across words and falls only while the last word is being acknowledged. A configuration enable gates the whole port.

Top module: `dack_dma_port`

## Requirements
- R1: After reset, `dreq_o`, `bus_oe_o`, `fifo_ready`, `done_o` are 0 and `words_left_o` is 0.
- R2: With `cfg_en`=1 and the port idle or done, a `pkt_start` pulse loads `words_left_o` with WORDS (32 by default) at the next clock edge. With `cfg_en`=0, `pkt_start` is ignored: `words_left_o` stays 0 and `dreq_o` stays 0.
- R3: `bus_oe_o` is 1 only while `dack_i` is 1 during an active transfer, and it falls in the same cycle as `dack_i`. While `bus_oe_o` is 1, `bus_data_o` equals `fifo_data`. Otherwise `bus_data_o` is 0.
- R4: When `dack_i` is seen low after a word was acknowledged, `fifo_ready` is 1 for that cycle only. `words_left_o` drops by exactly 1 at the next edge, so each acknowledge pops exactly one word.
- R5: In single-cycle mode (`cfg_burst`=0), `dreq_o` is 0 while an acknowledged word is on the bus. It returns to 1 in the cycle after `dack_i` is seen low, provided words remain and `fifo_valid` is 1.
- R6: In burst mode (`cfg_burst`=1), `dreq_o` stays 1 while a word is acknowledged if more than one word remains. It is 0 while the last word is acknowledged.
- R7: After the last pop, `done_o` is 1, `dreq_o` is 0 and `words_left_o` is 0 until the next `pkt_start`. While done, `dack_i` neither drives the bus nor pops.
- R8: In the request phase, `dreq_o` follows `fifo_valid` in the same cycle. An acknowledge that arrives while `fifo_valid` is 0 is ignored and does not drive the bus.
- R9: Clearing `cfg_en` returns the port to idle at the next edge: `dreq_o`, `bus_oe_o` and `done_o` are 0 and `words_left_o` is 0.
- R10: A `pkt_start` pulse during a packet transfer is ignored; the word count continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enables the acknowledge-strobed port |
| cfg_burst | input | 1 | 1 = burst request policy, 0 = single-cycle |
| pkt_start | input | 1 | One-cycle pulse: a full packet waits in the FIFO |
| fifo_data | input | DW | Word at the FIFO head |
| fifo_valid | input | 1 | FIFO head word is valid |
| fifo_ready | output | 1 | Pops the FIFO head word |
| dack_i | input | 1 | DMA acknowledge, also the data strobe |
| dreq_o | output | 1 | DMA request |
| bus_data_o | output | DW | Data toward the system bus |
| bus_oe_o | output | 1 | Bus drive enable (0 = bus released) |
| done_o | output | 1 | Packet fully transferred |
| words_left_o | output | $clog2(WORDS+1) | Words still to transfer |

## Verification
`dreq_o`, `bus_oe_o`, `bus_data_o` and `fifo_ready` are combinational on the state and on `dack_i`/`fifo_valid`. Their results are therefore due in the same cycle as the stimulus. The bench changes inputs on the falling clock edge and samples these outputs 1 ns later, before the next rising edge. `words_left_o`, `done_o` and the request-policy phase come from registers and change one rising edge after the stimulus. The bench checks them at the following falling edge, exactly one register stage later.

// File: rtl/dackdma_pkg.sv
package dackdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } dstate_t;
endpackage

// File: rtl/dackdma_seq.sv
module dackdma_seq
  import dackdma_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cfg_en,
  input  logic    cfg_burst,
  input  logic    pkt_start,
  input  logic    dack_i,
  input  logic    fifo_valid,
  input  logic    last_word,
  output dstate_t state_q,
  output logic    dreq,
  output logic    pop,
  output logic    load,
  output logic    clr
);
  dstate_t nxt;

  always_comb begin
    nxt  = state_q;
    load = 1'b0;
    pop  = 1'b0;
    clr  = !cfg_en;
    if (!cfg_en) begin
      nxt = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (pkt_start) begin
          nxt  = ST_REQ;
          load = 1'b1;
        end
        ST_REQ: if (dack_i && fifo_valid) nxt = ST_XFER;
        ST_XFER: if (!dack_i && fifo_valid) begin
          pop = 1'b1;
          nxt = last_word ? ST_DONE : ST_REQ;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= nxt;
  end

  // request: single mode withholds while a word is acknowledged,
  // burst mode keeps it up except during the final word
  assign dreq = cfg_en &&
                ((state_q == ST_REQ && fifo_valid) ||
                 (state_q == ST_XFER && cfg_burst && !last_word));
endmodule

// File: rtl/dackdma_cnt.sv
module dackdma_cnt #(
  parameter int WORDS = 32,
  localparam int CW = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          pop,
  output logic [CW-1:0] words_left,
  output logic          last_word
);
  localparam logic [CW-1:0] FULL = CW'(WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            words_left <= '0;
    else if (clr)                          words_left <= '0;
    else if (load)                         words_left <= FULL;
    else if (pop && words_left != '0)      words_left <= words_left - CW'(1);
  end

  assign last_word = (words_left == CW'(1));
endmodule

// File: rtl/dackdma_bus.sv
module dackdma_bus #(
  parameter int DW = 16
) (
  input  logic          dack_i,
  input  logic          drive_ok,
  input  logic [DW-1:0] data_in,
  output logic          oe,
  output logic [DW-1:0] data_out
);
  assign oe = dack_i && drive_ok;

  for (genvar b = 0; b < DW; b++) begin : g_lane
    assign data_out[b] = oe & data_in[b];
  end
endmodule

// File: rtl/dack_dma_port.sv
module dack_dma_port
  import dackdma_pkg::*;
#(
  parameter int DW    = 16,
  parameter int WORDS = 32,
  localparam int CW   = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_burst,
  input  logic          pkt_start,
  input  logic [DW-1:0] fifo_data,
  input  logic          fifo_valid,
  output logic          fifo_ready,
  input  logic          dack_i,
  output logic          dreq_o,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_oe_o,
  output logic          done_o,
  output logic [CW-1:0] words_left_o
);
  dstate_t state;
  logic    last_word, load, clr, drive_ok;

  dackdma_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_burst (cfg_burst),
    .pkt_start (pkt_start),
    .dack_i    (dack_i),
    .fifo_valid(fifo_valid),
    .last_word (last_word),
    .state_q   (state),
    .dreq      (dreq_o),
    .pop       (fifo_ready),
    .load      (load),
    .clr       (clr)
  );

  dackdma_cnt #(.WORDS(WORDS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .load      (load),
    .pop       (fifo_ready),
    .words_left(words_left_o),
    .last_word (last_word)
  );

  assign drive_ok = cfg_en &&
                    ((state == ST_REQ && fifo_valid) || state == ST_XFER);

  dackdma_bus #(.DW(DW)) u_bus (
    .dack_i  (dack_i),
    .drive_ok(drive_ok),
    .data_in (fifo_data),
    .oe      (bus_oe_o),
    .data_out(bus_data_o)
  );

  assign done_o = (state == ST_DONE);
endmodule

// File: rtl/dackdma_chk.sv
module dackdma_chk #(
  parameter int WORDS = 32,
  localparam int CW   = $clog2(WORDS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          cfg_burst,
  input logic          fifo_valid,
  input logic          fifo_ready,
  input logic          dack_i,
  input logic          dreq_o,
  input logic          bus_oe_o,
  input logic          done_o,
  input logic [CW-1:0] words_left_o
);
  // R3
  oe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> dack_i);

  // R4
  pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> (fifo_valid && !dack_i));

  // R4
  pop_counts_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |=> ($past(words_left_o) == words_left_o + CW'(1)));

  // R5
  single_holds_req_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_burst && dack_i && $past(dack_i) && $past(bus_oe_o)) |-> !dreq_o);

  // R6
  burst_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_burst && bus_oe_o && words_left_o > CW'(1)) |-> dreq_o);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!dreq_o && !bus_oe_o && words_left_o == '0));

  // R9
  disable_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!dreq_o && !done_o && words_left_o == '0));
endmodule

bind dack_dma_port dackdma_chk #(.WORDS(WORDS)) u_chk (.*);

// File: tb/tb_dack_dma_port.sv
module tb_dack_dma_port;
  localparam int DW = 16;
  localparam int WORDS = 32;
  localparam int CW = $clog2(WORDS + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, cfg_en, cfg_burst, pkt_start, fifo_valid, dack_i;
  logic [DW-1:0] fifo_data, bus_data_o;
  logic          fifo_ready, dreq_o, bus_oe_o, done_o;
  logic [CW-1:0] words_left_o;

  int checks = 0, errors = 0;
  int fifo_idx = 0, base = 0, pkt_id = 0;
  bit finished = 0;

  dack_dma_port #(.DW(DW), .WORDS(WORDS)) dut (.*);

  function automatic logic [DW-1:0] word_of(int p, int i);
    return DW'((p * 4369) ^ (i * 769) ^ 42435);
  endfunction

  // FIFO model: head advances on each pop
  always @(posedge clk) if (fifo_ready) fifo_idx <= fifo_idx + 1;
  assign fifo_data = word_of(pkt_id, fifo_idx - base);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_packet(bit burst, int p);
    cfg_burst = burst;
    pkt_id = p;
    base = fifo_idx;
    pkt_start = 1'b1;
    @(negedge clk); pkt_start = 1'b0;
    chk(words_left_o == CW'(WORDS), "R2 load", 32'(words_left_o), WORDS);
    chk(done_o == 1'b0, "R7 clear", 32'(done_o), 0);
    for (int k = 0; k < WORDS; k++) begin
      logic [DW-1:0] exp = word_of(p, k);
      int left = WORDS - k;
      // request phase with random valid stalls and stray acks
      forever begin
        bit poke;
        fifo_valid = ($urandom % 4) != 0;
        poke = !fifo_valid && ($urandom % 3 == 0);
        dack_i = poke;
        #1;
        chk(dreq_o == fifo_valid, "R8/R5 request", 32'(dreq_o), 32'(fifo_valid));
        if (poke) chk(bus_oe_o == 1'b0, "R8 stray ack", 32'(bus_oe_o), 0);
        if (fifo_valid) break;
        @(negedge clk);
      end
      dack_i = 1'b1;
      pkt_start = (k == 3);
      #1;
      chk(bus_oe_o && bus_data_o == exp, "R3 drive", 32'(bus_data_o), 32'(exp));
      for (int h = 0; h <= int'($urandom % 3); h++) begin
        @(negedge clk); pkt_start = 1'b0; #1;
        chk(bus_oe_o && bus_data_o == exp, "R3 hold", 32'(bus_data_o), 32'(exp));
        chk(dreq_o == (burst && left != 1), burst ? "R6 burst req" : "R5 single req",
            32'(dreq_o), 32'(burst && left != 1));
        chk(fifo_ready == 1'b0, "R4 no early pop", 32'(fifo_ready), 0);
      end
      dack_i = 1'b0;
      #1;
      chk(bus_oe_o == 1'b0 && bus_data_o == '0, "R3 release", 32'(bus_oe_o), 0);
      chk(fifo_ready == 1'b1, "R4 pop", 32'(fifo_ready), 1);
      @(negedge clk);
      chk(words_left_o == CW'(left - 1), "R4/R10 count", 32'(words_left_o), left - 1);
      chk(fifo_idx - base == k + 1, "R4 one pop", fifo_idx - base, k + 1);
      if (left == 1)
        chk(done_o && !dreq_o, "R7 done", {done_o, dreq_o}, 2);
      else
        chk(!done_o, "R7 not done", 32'(done_o), 0);
    end
    // acknowledges after completion are ignored
    dack_i = 1'b1; #1;
    chk(bus_oe_o == 1'b0, "R7 no drive", 32'(bus_oe_o), 0);
    @(negedge clk); dack_i = 1'b0; #1;
    chk(fifo_ready == 1'b0, "R7 no pop", 32'(fifo_ready), 0);
    @(negedge clk);
    chk(done_o && words_left_o == '0, "R7 hold", 32'(words_left_o), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1161));
    rst_n = 1'b0; cfg_en = 1'b0; cfg_burst = 1'b0; pkt_start = 1'b0;
    fifo_valid = 1'b1; dack_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!dreq_o && !bus_oe_o && !fifo_ready && !done_o && words_left_o == '0,
        "R1 reset", {dreq_o, bus_oe_o, fifo_ready, done_o}, 0);
    rst_n = 1'b1;
    // start while disabled is ignored
    @(negedge clk); pkt_start = 1'b1;
    @(negedge clk); pkt_start = 1'b0;
    chk(words_left_o == '0 && !dreq_o, "R2 disabled", 32'(words_left_o), 0);
    // disable mid-packet
    cfg_en = 1'b1; pkt_start = 1'b1;
    @(negedge clk); pkt_start = 1'b0;
    chk(dreq_o == 1'b1, "R2 request", 32'(dreq_o), 1);
    @(negedge clk); cfg_en = 1'b0;
    @(negedge clk); dack_i = 1'b1; #1;
    chk(!dreq_o && !bus_oe_o && !done_o && words_left_o == '0, "R9 idle",
        32'(words_left_o), 0);
    @(negedge clk); dack_i = 1'b0; cfg_en = 1'b1;
    @(negedge clk);
    run_packet(1'b0, 1);
    run_packet(1'b1, 2);
    for (int r = 0; r < 4; r++) run_packet(bit'($urandom % 2), 3 + r);
    finish_run();
  end
endmodule